// File: doc/BRIEF.md
# Smooth Calibration Pulse Adjuster

This block sits between a slow real-time reference tick and the prescaler that divides it. It trims the reference frequency digitally. Over a repeating calibration window it removes a programmed number of reference ticks and, when enabled, inserts extra ticks at a fixed rate. The prescaler then sees a corrected tick stream. With the default parameters and a 32.768 kHz reference, the window lasts 32 s. Two select inputs shorten it to 16 s or 8 s.

The removal count has `REM_W` bits. The insertion enable adds 2^`REM_W` ticks per full window. The net correction over a full window is therefore an addition of (2^`REM_W` × enable − count) ticks. Removal slots are spread through the window. The slot index is bit-reversed and compared against the count, so the suppressed ticks never bunch together. Settings are sampled only at a window boundary. A one-cycle boundary pulse is provided for observation.

The design has three assumptions. The input tick is a clock enable in the fast clock domain. It is never high on two consecutive cycles. Every inserted tick is issued on the first idle cycle that follows its slot.

Top module: `rtc_smooth_cal`

## Requirements
- R1: A synchronous active-low reset clears `tick_out` and `win_end`. It also zeroes the active settings: full window, no removal, no insertion. These settings remain in force until the first window boundary after reset, whatever the inputs are.
- R2: When no correction is active, each input tick produces exactly one `tick_out` pulse, one cycle later.
- R3: The window length in input ticks is 2^`WIN_LOG` with neither select set, 2^(`WIN_LOG`-1) with `win_half`=1, and 2^(`WIN_LOG`-2) with `win_quarter`=1. `win_quarter` takes priority when both selects are set.
- R4: `win_end` is a single-cycle pulse in the cycle after the last input tick of a window.
- R5: In a full window, exactly `rem_cnt` input ticks are suppressed.
- R6: In a half window, bit 0 of `rem_cnt` is treated as 0 and the suppressed count is `rem_cnt`/2. In a quarter window, bits 1:0 are treated as 0 and the suppressed count is `rem_cnt`/4.
- R7: With `ins_en`=1, one extra tick is issued for every 2^(`WIN_LOG`-`REM_W`) input ticks. It is placed in the middle of each such group, on the next cycle without an input tick.
- R8: A full window yields 2^`WIN_LOG` + 2^`REM_W`·`ins_en` − `rem_cnt` output ticks. Each shortened window yields the same total scaled by its length.
- R9: Suppression is spread evenly. The first half of a full window suppresses exactly ceil(`rem_cnt`/2) ticks.
- R10: A change to `rem_cnt`, `ins_en`, `win_half` or `win_quarter` has no effect on the current window. It applies from the window after the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Raw reference tick enable |
| rem_cnt | input | REM_W | Ticks to suppress per full window |
| ins_en | input | 1 | Enable periodic tick insertion |
| win_half | input | 1 | Select half-length window |
| win_quarter | input | 1 | Select quarter-length window (priority) |
| tick_out | output | 1 | Corrected tick enable |
| win_end | output | 1 | One-cycle window boundary pulse |

## Verification
The bench builds the block with `WIN_LOG`=8 and `REM_W`=4. A full window is then 256 ticks, with 16 removal slots and an insertion every 16 ticks. This makes it affordable to sweep every removal count, both insertion settings and all three window lengths. Each window total is compared against the closed-form count. The first-half count of each full window tests the spreading. A change made in the middle of a window shows the deferred loading of settings. The reset case shows that inputs are ignored until the first boundary.

// File: rtl/rtc_cal_pkg.sv
// Shared types for the smooth calibration adjuster.
// Assumes nothing beyond a two-bit window-length code.
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        WIN_FULL    = 2'd0,
        WIN_HALF    = 2'd1,
        WIN_QUARTER = 2'd2
    } win_sel_e;

    // Turn the two select inputs into a window code; quarter has priority.
    function automatic win_sel_e sel_decode(input logic half, input logic quarter);
        if (quarter) return WIN_QUARTER;
        if (half)    return WIN_HALF;
        return WIN_FULL;
    endfunction

endpackage

// File: rtl/cal_cfg_latch.sv
// Holds the calibration settings for the running window.
// It loads a fresh copy (with low count bits masked for short windows) on load.
// Assumes REM_W >= 2.
module cal_cfg_latch
    import rtc_cal_pkg::*;
#(
    parameter int REM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REM_W-1:0] rem_in,
    input  logic             ins_in,
    input  logic             half_in,
    input  logic             quarter_in,
    output logic [REM_W-1:0] rem_q,
    output logic             ins_q,
    output win_sel_e         sel_q
);

    win_sel_e         sel_next;
    logic [REM_W-1:0] rem_masked;

    // Decode the window and clear the count bits the short windows cannot use.
    always_comb begin
        sel_next   = sel_decode(half_in, quarter_in);
        rem_masked = rem_in;
        case (sel_next)
            WIN_HALF:    rem_masked[0]   = 1'b0;
            WIN_QUARTER: rem_masked[1:0] = 2'b00;
            default:     rem_masked      = rem_in;
        endcase
    end

    // Capture the settings at a window boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            ins_q <= 1'b0;
            sel_q <= WIN_FULL;
        end else if (load) begin
            rem_q <= rem_masked;
            ins_q <= ins_in;
            sel_q <= sel_next;
        end
    end

endmodule

// File: rtl/cal_window_ctr.sv
// Counts input ticks within the calibration window and flags the final tick.
// The counter always restarts from zero, so short windows use its low range.
// Assumes WIN_LOG >= 3.
module cal_window_ctr
    import rtc_cal_pkg::*;
#(
    parameter int WIN_LOG = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  win_sel_e           sel,
    output logic [WIN_LOG-1:0] cnt,
    output logic               wrap
);

    logic [WIN_LOG-1:0] last;

    // Pick the final count value for the active window length.
    always_comb begin
        case (sel)
            WIN_HALF:    last = {1'b0, {(WIN_LOG-1){1'b1}}};
            WIN_QUARTER: last = {2'b00, {(WIN_LOG-2){1'b1}}};
            default:     last = {WIN_LOG{1'b1}};
        endcase
        wrap = tick && (cnt == last);
    end

    // Advance on each input tick and clear at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cal_pulse_shaper.sv
// Decides per input tick whether to drop it, and when to issue inserted ticks.
// Removal slots sit at group offset 0. The slot index is bit-reversed and
// compared against the count. Insertions are armed at mid-group and issued on
// the next idle cycle.
// Assumes tick is never high on two consecutive cycles.
module cal_pulse_shaper #(
    parameter int WIN_LOG = 20,
    parameter int REM_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [WIN_LOG-1:0] cnt,
    input  logic [REM_W-1:0]   rem_q,
    input  logic               ins_q,
    output logic               drop_now,
    output logic               ins_pend,
    output logic               tick_out
);

    localparam int SUB_W = WIN_LOG - REM_W;
    localparam logic [SUB_W-1:0] MID_SUB = {1'b1, {(SUB_W-1){1'b0}}};

    logic [REM_W-1:0] slot;
    logic [REM_W-1:0] slot_rev;
    logic             ins_hit;

    assign slot = cnt[WIN_LOG-1:SUB_W];

    // Mirror the slot index bit by bit.
    for (genvar i = 0; i < REM_W; i++) begin : g_rev
        assign slot_rev[i] = slot[REM_W-1-i];
    end

    // Removal and insertion slot decisions for the current tick.
    always_comb begin
        drop_now = tick && (cnt[SUB_W-1:0] == '0) && (slot_rev < rem_q);
        ins_hit  = tick && ins_q && (cnt[SUB_W-1:0] == MID_SUB);
    end

    // Arm on an insertion slot and release on the first idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)             ins_pend <= 1'b0;
        else if (ins_hit)       ins_pend <= 1'b1;
        else if (!tick)         ins_pend <= 1'b0;
    end

    // Register the corrected tick: passed input ticks plus released insertions.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= (tick && !drop_now) || (!tick && ins_pend);
    end

endmodule

// File: rtl/rtc_smooth_cal.sv
// Top of the smooth calibration adjuster. It ties the settings latch, the window
// counter and the pulse shaper together, and registers the boundary pulse.
// Assumes tick_in is a single-cycle enable with at least one idle cycle between ticks.
module rtc_smooth_cal
    import rtc_cal_pkg::*;
#(
    parameter int WIN_LOG = 20,
    parameter int REM_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [REM_W-1:0] rem_cnt,
    input  logic             ins_en,
    input  logic             win_half,
    input  logic             win_quarter,
    output logic             tick_out,
    output logic             win_end
);

    logic [WIN_LOG-1:0] cnt;
    logic               wrap;
    logic [REM_W-1:0]   rem_q;
    logic               ins_q;
    win_sel_e           sel_q;
    logic               drop_now;
    logic               ins_pend;

    cal_cfg_latch #(.REM_W(REM_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wrap),
        .rem_in     (rem_cnt),
        .ins_in     (ins_en),
        .half_in    (win_half),
        .quarter_in (win_quarter),
        .rem_q      (rem_q),
        .ins_q      (ins_q),
        .sel_q      (sel_q)
    );

    cal_window_ctr #(.WIN_LOG(WIN_LOG)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_in),
        .sel   (sel_q),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    cal_pulse_shaper #(.WIN_LOG(WIN_LOG), .REM_W(REM_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_in),
        .cnt      (cnt),
        .rem_q    (rem_q),
        .ins_q    (ins_q),
        .drop_now (drop_now),
        .ins_pend (ins_pend),
        .tick_out (tick_out)
    );

    // Boundary pulse, aligned with the output of the window's last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) win_end <= 1'b0;
        else        win_end <= wrap;
    end

endmodule

// File: rtl/rtc_smooth_cal_chk.sv
// Property checker for rtc_smooth_cal, attached through bind below.
module rtc_smooth_cal_chk
    import rtc_cal_pkg::*;
#(
    parameter int REM_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             tick_out,
    input logic             win_end,
    input logic             wrap,
    input logic [REM_W-1:0] rem_q,
    input logic             ins_q,
    input win_sel_e         sel_q,
    input logic             drop_now,
    input logic             ins_pend
);

    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    assert_reset_state_R1: assert property (@(posedge clk)
        (past_valid && !$past(rst_n)) |-> (!tick_out && !win_end && rem_q == '0 && !ins_q && sel_q == WIN_FULL));

    assert_out_source_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        tick_out |-> ($past(tick_in) || $past(ins_pend)));

    assert_end_single_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        win_end |=> !win_end);

    assert_no_drop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_now |-> (rem_q != '0));

    assert_mask_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == WIN_HALF) |-> (rem_q[0] == 1'b0));

    assert_mask_quarter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == WIN_QUARTER) |-> (rem_q[1:0] == 2'b00));

    assert_pend_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_pend |-> ins_q);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        (!$past(wrap) && $past(rst_n)) |-> ($stable(rem_q) && $stable(ins_q) && $stable(sel_q)));

endmodule

bind rtc_smooth_cal rtc_smooth_cal_chk #(.REM_W(REM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .tick_out (tick_out),
    .win_end  (win_end),
    .wrap     (wrap),
    .rem_q    (rem_q),
    .ins_q    (ins_q),
    .sel_q    (sel_q),
    .drop_now (drop_now),
    .ins_pend (ins_pend)
);

// File: tb/sim_rtc_smooth_cal.sv
`timescale 1ns/1ps
module sim_rtc_smooth_cal;

    localparam int WL = 8;
    localparam int RW = 4;
    localparam int FULL = 1 << WL;
    localparam int INS_PER_WIN = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_in = 1'b0;
    logic [RW-1:0] rem_cnt = '0;
    logic          ins_en = 1'b0;
    logic          win_half = 1'b0;
    logic          win_quarter = 1'b0;
    logic          tick_out;
    logic          win_end;
    logic          run_ticks = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int out_cnt = 0;
    int in_win = 0;
    int last_total = 0;
    int last_len = 0;
    int half_snap = 0;
    int win_seen = 0;

    rtc_smooth_cal #(.WIN_LOG(WL), .REM_W(RW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_in     (tick_in),
        .rem_cnt     (rem_cnt),
        .ins_en      (ins_en),
        .win_half    (win_half),
        .win_quarter (win_quarter),
        .tick_out    (tick_out),
        .win_end     (win_end)
    );

    always #5 clk = ~clk;

    // Reference ticks on alternate cycles, changed just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick_in = run_ticks ? ~tick_in : 1'b0;
        end
    end

    // Port monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            out_cnt = 0;
            in_win  = 0;
        end else begin
            if (tick_in) in_win++;
            if (tick_out) out_cnt++;
            if (tick_in && in_win == FULL / 2 + 1) half_snap = out_cnt;
            if (win_end) begin
                last_total = out_cnt;
                last_len   = in_win;
                win_seen++;
                out_cnt = 0;
                in_win  = 0;
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_windows(input int n);
        int target;
        target = win_seen + n;
        while (win_seen < target) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input int r, input int e, input int k);
        @(posedge clk);
        #1;
        rem_cnt     = RW'(r);
        ins_en      = (e != 0);
        win_half    = (k == 1);
        win_quarter = (k == 2);
    endtask

    function automatic int expect_total(input int r, input int e, input int k);
        int masked;
        masked = (k == 0) ? r : (k == 1) ? (r & ~1) : (r & ~3);
        return (FULL >> k) + ((INS_PER_WIN * e) >> k) - (masked >> k);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state, with non-zero settings already on the inputs
        apply(5, 1, 2);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick_out after reset", int'(tick_out), 0);
        check("R1 win_end after reset", int'(win_end), 0);
        run_ticks = 1'b1;
        wait_windows(1);
        check("R1 first window total", last_total, FULL);
        check("R1 first window length", last_len, FULL);
        wait_windows(1);
        check("R6 quarter window with count 5", last_total, expect_total(5, 1, 2));
        check("R3 quarter priority length", last_len, FULL / 4);

        // R3 R5 R6 R7 R8 R9: sweep every setting
        for (int k = 0; k < 3; k++) begin
            for (int e = 0; e < 2; e++) begin
                for (int r = 0; r < INS_PER_WIN; r++) begin
                    apply(r, e, k);
                    wait_windows(1);
                    wait_windows(1);
                    check("R8 window total", last_total, expect_total(r, e, k));
                    check("R3 window length", last_len, FULL >> k);
                    if (k == 0) begin
                        check("R9 first half count", half_snap,
                              FULL / 2 + (INS_PER_WIN / 2) * e - (r + 1) / 2);
                    end
                end
            end
        end

        // R2: no correction gives pass-through
        apply(0, 0, 0);
        wait_windows(2);
        check("R2 pass-through total", last_total, FULL);

        // R10: a change in mid-window leaves the current window untouched
        repeat (100) @(posedge clk);
        apply(15, 1, 0);
        wait_windows(1);
        check("R10 current window unchanged", last_total, FULL);
        wait_windows(1);
        check("R10 next window updated", last_total, FULL + INS_PER_WIN - 15);

        // R4: a boundary pulse lasts one cycle
        wait(win_end);
        @(negedge clk);
        @(negedge clk);
        check("R4 win_end single cycle", int'(win_end), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule